// File: doc/BRIEF.md
# Packed-Nibble Allocation Tag Check Engine

This engine decides whether a tagged pointer may touch memory. The pointer carries a 4-bit logical tag in bits 59:56. Tag storage keeps one 4-bit allocation tag for every 16-byte granule, and packs two of them into each byte. An access starts at the pointer and spans `size_m1 + 1` bytes. The engine works out which granules the access covers. It fetches the packed tag bytes one per cycle through a synchronous read port and compares each covered granule's tag with the pointer tag, stopping at the first one that differs.

When the engine finishes it pulses `done` and holds `pass` and `fault_addr` until the next request. On a mismatch, `fault_addr` names the first failing granule. The pointer itself is reported when the very first granule fails. Two controls can bypass the memory check. `tbi_en` enables checking separately for each address half, selected by pointer bit 55. `mall_en` enables a match-all tag for each half. Pointers in the range are assumed not to cross a page, and no address translation is done.

Top module: `tag_check_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `mem_rd_en` are all 0.
- R2: When `tbi_en[ptr[55]]` is 0, the request is unchecked. `done` rises in the cycle after `start` with `pass`=1 and `fault_addr`=`ptr`, and no tag read is issued.
- R3: When `mall_en[ptr[55]]` is 1 and the pointer tag `ptr[59:56]` equals 4'h0 (bit 55 clear) or 4'hF (bit 55 set), the request passes in the cycle after `start` with no tag read.
- R4: A checked request covers the granules from `ptr>>4` through `(ptr+size_m1)>>4`, using the low 48 bits. It passes only if every covered granule's stored tag equals `ptr[59:56]`.
- R5: The tag byte at address `A` holds the granule with physical address bit 4 = 0 in bits 3:0 and its neighbour with bit 4 = 1 in bits 7:4. The byte address is `pa>>5`. Checking starts at bits 7:4 of the first byte when `ptr[4]` is 1. A nibble outside the covered range never causes a failure.
- R6: Tag reads go out on consecutive cycles at consecutive byte addresses, starting at `ptr[47:5]`. The read data is used one cycle after the read. A passing request issues exactly `((ptr+size_m1)>>5) - (ptr>>5) + 1` reads, and no read is issued while idle.
- R7: On a failing request, `pass`=0. `fault_addr` is `ptr` when the first granule fails. Otherwise it is `{ptr[63:4],4'h0}` plus 16 times the number of granules that matched before the failure.
- R8: A `start` while `busy` is high is ignored, and the running request completes with its own result.
- R9: `done` is a single-cycle pulse given while idle, and `pass` and `fault_addr` stay stable until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted while idle |
| ptr | input | 64 | Tagged pointer: tag in 59:56, half select in 55, physical address in 47:0 |
| size_m1 | input | SZ_W | Access size in bytes minus one |
| tbi_en | input | 2 | Checking enable per address half |
| mall_en | input | 2 | Match-all bypass enable per address half |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last request |
| fault_addr | output | 64 | First failing address of the last request |
| mem_rd_en | output | 1 | Tag byte read strobe |
| mem_addr | output | PA_W-5 | Tag byte address |
| mem_rdata | input | 8 | Tag byte, valid the cycle after the read |

## Verification
The hardest cases to reach are those where a wrong tag sits in the unused half of a boundary byte. This happens when the access starts in the upper nibble or ends in the lower nibble. Only correct nibble masking keeps such a request passing. The stimulus table places a single poisoned granule just outside the range in both positions. It also places poisoned granules at the first, an interior and the last granule of odd and even starting points. This makes the count of matched granules, and therefore the fault address, differ in each case. A second start issued mid-run shows that the running request is left alone.

// File: rtl/tagchk_pkg.sv
// Shared constants and types for the tag check engine.
// Assumes a 64-bit tagged pointer with the tag in bits 59:56.
package tagchk_pkg;
    localparam int PTR_W   = 64;
    localparam int TAG_W   = 4;
    localparam int TAG_LSB = 56;
    localparam int SEL_BIT = 55;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tagchk_state_e;
endpackage

// File: rtl/tagchk_span.sv
// Computes the granule count, the tag byte count and the first tag byte
// address for an access. Assumes the access does not wrap the physical space.
module tagchk_span #(
    parameter int PA_W    = 48,
    parameter int SZ_W    = 8,
    parameter int GRAN_LG = 4,
    parameter int CNT_W   = SZ_W - GRAN_LG + 2,
    parameter int TA_W    = PA_W - GRAN_LG - 1
) (
    input  logic [PA_W-1:0]  pa,
    input  logic [SZ_W-1:0]  size_m1,
    output logic [CNT_W-1:0] n_tags,
    output logic [CNT_W-1:0] n_bytes,
    output logic [TA_W-1:0]  byte_first
);
    logic [PA_W-1:0]         pa_last;
    logic [PA_W-GRAN_LG-1:0] gdiff;
    logic [TA_W-1:0]         bdiff;

    // Range arithmetic on granule and tag byte indices.
    always_comb begin
        pa_last    = pa + PA_W'(size_m1);
        gdiff      = pa_last[PA_W-1:GRAN_LG] - pa[PA_W-1:GRAN_LG];
        bdiff      = pa_last[PA_W-1:GRAN_LG+1] - pa[PA_W-1:GRAN_LG+1];
        n_tags     = CNT_W'(gdiff) + CNT_W'(1);
        n_bytes    = CNT_W'(bdiff) + CNT_W'(1);
        byte_first = pa[PA_W-1:GRAN_LG+1];
    end
endmodule

// File: rtl/tagchk_nibcmp.sv
// Compares the enabled nibbles of one packed tag byte with the pointer tag.
// Assumes the lower nibble is checked before the upper one.
module tagchk_nibcmp #(
    parameter int TAG_W = 4
) (
    input  logic [2*TAG_W-1:0] tag_byte,
    input  logic [TAG_W-1:0]   tag,
    input  logic [1:0]         nib_en,
    output logic [1:0]         good,
    output logic               bad
);
    logic [1:0] nib_bad;

    for (genvar i = 0; i < 2; i++) begin : g_nib
        assign nib_bad[i] = nib_en[i] && (tag_byte[i*TAG_W +: TAG_W] != tag);
    end

    // Matches counted up to the first failing nibble.
    always_comb begin
        bad = |nib_bad;
        if (nib_bad[0])
            good = 2'd0;
        else
            good = {1'b0, nib_en[0]} + {1'b0, nib_en[1] && !nib_bad[1]};
    end
endmodule

// File: rtl/tag_check_engine.sv
// Tag check engine: fetches packed tag bytes one per cycle and checks every
// covered granule against the pointer tag. Assumes a tag memory with a
// single-cycle read latency and an access that stays within one page.
module tag_check_engine #(
    parameter int PA_W    = 48,
    parameter int SZ_W    = 8,
    parameter int GRAN_LG = 4,
    localparam int CNT_W  = SZ_W - GRAN_LG + 2,
    localparam int TA_W   = PA_W - GRAN_LG - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      ptr,
    input  logic [SZ_W-1:0]  size_m1,
    input  logic [1:0]       tbi_en,
    input  logic [1:0]       mall_en,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [63:0]      fault_addr,
    output logic             mem_rd_en,
    output logic [TA_W-1:0]  mem_addr,
    input  logic [7:0]       mem_rdata
);
    import tagchk_pkg::*;

    tagchk_state_e          state;
    logic [PTR_W-1:0]       ptr_q;
    logic                   odd_q;
    logic [TA_W-1:0]        rd_addr;
    logic [CNT_W-1:0]       rd_left;
    logic [CNT_W-1:0]       rem;
    logic [CNT_W-1:0]       nmatch;
    logic                   cmp_vld;
    logic                   cmp_first;
    logic                   done_q;
    logic                   pass_q;
    logic [PTR_W-1:0]       fault_q;

    logic [CNT_W-1:0]       n_tags;
    logic [CNT_W-1:0]       n_bytes;
    logic [TA_W-1:0]        byte_first;
    logic [1:0]             nib_en;
    logic [1:0]             good;
    logic                   bad;
    logic                   finish;
    logic [CNT_W-1:0]       nmatch_nxt;
    logic                   sel;
    logic                   bypass;
    logic [TAG_W-1:0]       tag_q;

    tagchk_span #(
        .PA_W(PA_W), .SZ_W(SZ_W), .GRAN_LG(GRAN_LG), .CNT_W(CNT_W), .TA_W(TA_W)
    ) u_span (
        .pa(ptr[PA_W-1:0]),
        .size_m1(size_m1),
        .n_tags(n_tags),
        .n_bytes(n_bytes),
        .byte_first(byte_first)
    );

    tagchk_nibcmp #(.TAG_W(TAG_W)) u_cmp (
        .tag_byte(mem_rdata),
        .tag(tag_q),
        .nib_en(nib_en),
        .good(good),
        .bad(bad)
    );

    // Request decode: bypass when checking is off or the tag matches all.
    always_comb begin
        sel    = ptr[SEL_BIT];
        bypass = !tbi_en[sel] ||
                 (mall_en[sel] && (ptr[TAG_LSB +: TAG_W] == {TAG_W{sel}}));
    end

    // Nibble enables for the byte arriving this cycle and the stop decision.
    always_comb begin
        tag_q      = ptr_q[TAG_LSB +: TAG_W];
        nib_en[0]  = cmp_vld && !(cmp_first && odd_q);
        nib_en[1]  = cmp_vld && (rem > CNT_W'(nib_en[0]));
        finish     = cmp_vld && (bad || (rem == CNT_W'(good)));
        nmatch_nxt = nmatch + CNT_W'(good);
    end

    // Control and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ptr_q     <= '0;
            odd_q     <= 1'b0;
            rd_addr   <= '0;
            rd_left   <= '0;
            rem       <= '0;
            nmatch    <= '0;
            cmp_vld   <= 1'b0;
            cmp_first <= 1'b0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            fault_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q <= ptr;
                        if (bypass) begin
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                            fault_q <= ptr;
                        end else begin
                            state     <= ST_RUN;
                            odd_q     <= ptr[GRAN_LG];
                            rd_addr   <= byte_first;
                            rd_left   <= n_bytes;
                            rem       <= n_tags;
                            nmatch    <= '0;
                            cmp_vld   <= 1'b0;
                            cmp_first <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (mem_rd_en) begin
                        rd_addr <= rd_addr + TA_W'(1);
                        rd_left <= rd_left - CNT_W'(1);
                    end
                    cmp_vld <= mem_rd_en && !finish;
                    if (cmp_vld) begin
                        rem       <= rem - CNT_W'(good);
                        nmatch    <= nmatch_nxt;
                        cmp_first <= 1'b0;
                    end
                    if (finish) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        pass_q <= !bad;
                        if (!bad || nmatch_nxt == '0)
                            fault_q <= ptr_q;
                        else
                            fault_q <= {ptr_q[PTR_W-1:GRAN_LG] + (PTR_W-GRAN_LG)'(nmatch_nxt),
                                        {GRAN_LG{1'b0}}};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_RUN);
    assign mem_rd_en  = (state == ST_RUN) && (rd_left != '0);
    assign mem_addr   = rd_addr;
    assign done       = done_q;
    assign pass       = pass_q;
    assign fault_addr = fault_q;
endmodule

// File: rtl/tagchk_chk.sv
// Protocol checks for the tag check engine, bound to every instance.
module tagchk_chk #(
    parameter int TA_W = 43
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            sel,
    input logic [1:0]      tbi_en,
    input logic            busy,
    input logic            done,
    input logic            pass,
    input logic            mem_rd_en,
    input logic [TA_W-1:0] mem_addr
);
    // R2
    unchecked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !tbi_en[sel] |=> done && pass && !mem_rd_en);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    // R6
    rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + TA_W'(1));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind tag_check_engine tagchk_chk #(.TA_W(TA_W)) u_tagchk_chk (
    .clk(clk),
    .rst_n(rst_n),
    .start(start),
    .sel(ptr[55]),
    .tbi_en(tbi_en),
    .busy(busy),
    .done(done),
    .pass(pass),
    .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr)
);

// File: tb/sim_tag_check_engine.sv
`timescale 1ns/1ps
module sim_tag_check_engine;
    localparam int TA_W = 43;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [63:0]     ptr = '0;
    logic [7:0]      size_m1 = '0;
    logic [1:0]      tbi_en = 2'b11;
    logic [1:0]      mall_en = 2'b00;
    logic            busy, done, pass, mem_rd_en;
    logic [63:0]     fault_addr;
    logic [TA_W-1:0] mem_addr;
    logic [7:0]      mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    logic [3:0] gtag [128];

    always #2.5 clk = ~clk;

    tag_check_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr(ptr), .size_m1(size_m1),
        .tbi_en(tbi_en), .mall_en(mall_en), .busy(busy), .done(done), .pass(pass),
        .fault_addr(fault_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    // Tag memory model: one byte per read, one cycle latency, low nibble = even granule.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= {gtag[2*int'(mem_addr[5:0])+1], gtag[2*int'(mem_addr[5:0])]};
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] p, input logic [7:0] s, output int cyc);
        @(negedge clk);
        start = 1'b1; ptr = p; size_m1 = s; rd_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 100) chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    endtask

    function automatic logic [63:0] mkptr(input logic [3:0] t, input logic [15:0] pa);
        return {4'h0, t, 40'h0, pa};
    endfunction

    // Vector: {pa[15:0], tag[3:0], size_m1[7:0], bad granule[7:0] (FF none), expected pass}
    localparam logic [36:0] VEC [14] = '{
        {16'h0100, 4'h5, 8'd15,  8'hFF, 1'b1},  // R4 one granule
        {16'h0110, 4'h5, 8'd15,  8'hFF, 1'b1},  // R5 upper nibble start
        {16'h0108, 4'h5, 8'd15,  8'hFF, 1'b1},  // R4 two granules, one byte
        {16'h0118, 4'h5, 8'd15,  8'hFF, 1'b1},  // R5 two granules, two bytes
        {16'h0100, 4'h5, 8'd255, 8'hFF, 1'b1},  // R6 16 granules
        {16'h0108, 4'h5, 8'd255, 8'hFF, 1'b1},  // R6 17 granules
        {16'h0100, 4'h5, 8'd63,  8'd16, 1'b0},  // R7 first granule fails
        {16'h0104, 4'h5, 8'd63,  8'd18, 1'b0},  // R7 third granule fails
        {16'h0110, 4'h5, 8'd31,  8'd16, 1'b1},  // R5 lower nibble skipped
        {16'h0100, 4'h5, 8'd15,  8'd17, 1'b1},  // R5 upper nibble skipped
        {16'h0110, 4'h5, 8'd47,  8'd19, 1'b0},  // R7 odd start, later fail
        {16'h010C, 4'h5, 8'd255, 8'd32, 1'b0},  // R7 last granule fails
        {16'h0120, 4'h3, 8'd31,  8'hFF, 1'b0},  // R4 pointer tag differs
        {16'h01F0, 4'h5, 8'd0,   8'd31, 1'b0}   // R7 single odd granule fails
    };

    initial begin
        #(5.0 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        for (int g = 0; g < 128; g++) gtag[g] = 4'h5;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !pass && !mem_rd_en, "R1", {60'h0, busy, done, pass, mem_rd_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 14; v++) begin
            logic [15:0] pa;
            logic [3:0]  t;
            logic [7:0]  s, bg;
            logic        ep;
            logic [63:0] p, ef;
            int first, last, nb;
            {pa, t, s, bg, ep} = VEC[v];
            p = mkptr(t, pa);
            if (bg != 8'hFF) gtag[bg] = 4'hA;
            first = int'(pa) >> 4;
            last = (int'(pa) + int'(s)) >> 4;
            nb = ((int'(pa) + int'(s)) >> 5) - (int'(pa) >> 5) + 1;
            ef = p;
            for (int g = first; g <= last; g++) begin
                if (gtag[g] != t) begin
                    ef = (g == first) ? p : {p[63:16], 16'(g << 4)};
                    break;
                end
            end
            run(p, s, cyc);
            chk(pass == ep, "R4", 64'(pass), 64'(ep));
            if (!ep) chk(fault_addr == ef, "R7", fault_addr, ef);
            if (ep) chk(rd_cnt == nb, "R6", 64'(rd_cnt), 64'(nb));
            @(negedge clk);
            chk(!done, "R9", 64'(done), 64'd0);
            if (bg != 8'hFF) gtag[bg] = 4'h5;
        end

        // R9 result held after done
        chk(pass == 1'b0 && fault_addr == 64'h05000000000001F0, "R9", fault_addr, 64'h05000000000001F0);

        // R2 checking disabled for the lower half
        gtag[16] = 4'hA;
        tbi_en = 2'b10;
        run(mkptr(4'h5, 16'h0100), 8'd15, cyc);
        chk(pass && cyc == 1 && rd_cnt == 0, "R2", {32'(cyc), 32'(rd_cnt)}, {32'd1, 32'd0});
        chk(fault_addr == mkptr(4'h5, 16'h0100), "R2", fault_addr, mkptr(4'h5, 16'h0100));
        // R2 upper half disabled, bit 55 set
        tbi_en = 2'b01;
        run(mkptr(4'h5, 16'h0100) | (64'h1 << 55), 8'd15, cyc);
        chk(pass && cyc == 1 && rd_cnt == 0, "R2", {32'(cyc), 32'(rd_cnt)}, {32'd1, 32'd0});
        tbi_en = 2'b11;

        // R3 match-all on lower half with tag 0
        mall_en = 2'b01;
        run(mkptr(4'h0, 16'h0100), 8'd15, cyc);
        chk(pass && cyc == 1 && rd_cnt == 0, "R3", {32'(cyc), 32'(rd_cnt)}, {32'd1, 32'd0});
        // R3 upper half needs tag F
        mall_en = 2'b10;
        run(mkptr(4'hF, 16'h0100) | (64'h1 << 55), 8'd15, cyc);
        chk(pass && cyc == 1 && rd_cnt == 0, "R3", {32'(cyc), 32'(rd_cnt)}, {32'd1, 32'd0});
        // R3 disabled: tag 0 is checked and fails
        mall_en = 2'b00;
        run(mkptr(4'h0, 16'h0120), 8'd15, cyc);
        chk(!pass && rd_cnt == 1, "R3", {63'h0, pass}, 64'd0);
        gtag[16] = 4'h5;

        // R8 start while busy is ignored
        @(negedge clk);
        start = 1'b1; ptr = mkptr(4'h5, 16'h0108); size_m1 = 8'd255; rd_cnt = 0;
        @(negedge clk);
        ptr = mkptr(4'h3, 16'h0300); size_m1 = 8'd0;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk(pass && rd_cnt == 9, "R8", {32'(pass), 32'(rd_cnt)}, {32'd1, 32'd9});

        // R1 reset mid-run clears state
        @(negedge clk);
        start = 1'b1; ptr = mkptr(4'h5, 16'h0100); size_m1 = 8'd255;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pass && !mem_rd_en, "R1", {60'h0, busy, done, pass, mem_rd_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule